// File: doc/BRIEF.md
# Indexed Display Configuration Register Port

This block is the software-facing control port of a display adapter. It exposes three 32-bit I/O offsets. Software writes a register number to the selector port at offset 0, then reads or writes that register through the data port at offset 1. Offset 2 is a spare port that reads zero and ignores writes. The register set covers an adapter identity handshake, the mode enable, requested and active resolution, values derived from the fixed colour depth, hardware cursor state, a handshake that brings up the command ring, a sync/busy pair that starts the command engine, and a bank of general scratch words.

The handshake that brings up the ring only succeeds if the ring header words in shared memory are sane at the moment of the write. Those words reach the block on four input buses. Turning the mode off also takes down the ring. Read data is returned one cycle after the read strobe, qualified by a valid flag. The scratch bank is a single-port memory that can be mapped to block RAM.

Top module: `cfg_regport`

## Requirements
- R1: Offset 0 reads back the selected register number and a write to it changes the selection; offset 2 reads 0 and ignores writes; offset 3 reads 0xFFFFFFFF. Read data and `io_rvalid` appear in the cycle after `io_rd`. The register number is 0 after reset.
- R2: The identity register (number 0) resets to 0x90000002. A write to it is accepted only for 0x90000000, 0x90000001 or 0x90000002; any other value leaves it unchanged.
- R3: A write to the enable register (number 1) stores whether the value is nonzero, and the register reads back 1 or 0. A zero value drops `ring_ready`. Any write makes the active width and height (numbers 2 and 3) read 0xFFFFFFFF.
- R4: Writes to numbers 2 and 3 set the requested width and height. A `mode_apply` pulse copies them into the active values that those numbers read. Number 12 reads ((DEPTH+7)>>3) times the requested width.
- R5: Number 6 reads DEPTH and number 7 reads DEPTH+7 rounded down to a multiple of 8. A write to either of them with a value other than DEPTH drops `ring_ready`; a write equal to DEPTH has no effect.
- R6: A nonzero write to number 20 sets `ring_ready` only if each of the four ring words is a multiple of 4, the start word is at least 16, the end word is at most 0x10000, and the end word is at least the start word plus 10240. Otherwise `ring_ready` is unchanged. Number 20 reads `ring_ready`.
- R7: A zero write to number 20 drops `ring_ready`.
- R8: A write to number 21 sets the busy flag and raises `sync_start` for exactly one cycle. Numbers 21 and 22 both read the busy flag, which clears on a `sync_done` pulse.
- R9: A write to number 27 of value 1 sets `cursor_visible`, value 0 clears it, and values 2 and 3 leave it unchanged. Number 27 reads the flag.
- R10: Numbers 23 (guest code), 24 (cursor shape), 25 (cursor x) and 26 (cursor y) are plain read-write words.
- R11: Numbers 1024 to 1791 and every unassigned number read 0 and ignore writes.
- R12: Numbers from 1792 up to 1792 plus 2^SCRATCH_AW minus 1 are read-write scratch words. Number 29 reads 2^SCRATCH_AW. Numbers past the bank read 0.
- R13: Number 17 reads 3 (fill and copy capability bits 0 and 1). Numbers 4 and 5 read MAX_W and MAX_H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_off | input | 2 | Port offset: 0 selector, 1 data, 2 spare |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read data valid, one cycle after io_rd |
| ring_lo | input | 32 | Ring header start word |
| ring_hi | input | 32 | Ring header end word |
| ring_wp | input | 32 | Ring header producer word |
| ring_rp | input | 32 | Ring header consumer word |
| mode_apply | input | 1 | Pulse that copies the requested size into the active size |
| sync_done | input | 1 | Pulse from the command engine that clears busy |
| sync_start | output | 1 | One-cycle start pulse to the command engine |
| disp_enable | output | 1 | Mode enable state |
| ring_ready | output | 1 | Ring configured state |
| cursor_visible | output | 1 | Cursor shown flag |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high in the same cycle and that each strobe lasts one cycle. They also assume that the ring header words are stable around a write to number 20. The stimulus uses tasks that issue exactly one access per cycle. It changes the ring words only between accesses, and it pulses `mode_apply` and `sync_done` only when no write is in flight.

// File: rtl/cfg_regport_pkg.sv
package cfg_regport_pkg;
  localparam logic [1:0] OFF_SEL   = 2'd0;
  localparam logic [1:0] OFF_DATA  = 2'd1;
  localparam logic [1:0] OFF_SPARE = 2'd2;

  localparam logic [31:0] IX_ID      = 32'd0;
  localparam logic [31:0] IX_ENABLE  = 32'd1;
  localparam logic [31:0] IX_WIDTH   = 32'd2;
  localparam logic [31:0] IX_HEIGHT  = 32'd3;
  localparam logic [31:0] IX_MAXW    = 32'd4;
  localparam logic [31:0] IX_MAXH    = 32'd5;
  localparam logic [31:0] IX_DEPTH   = 32'd6;
  localparam logic [31:0] IX_BPP     = 32'd7;
  localparam logic [31:0] IX_PITCH   = 32'd12;
  localparam logic [31:0] IX_CAPS    = 32'd17;
  localparam logic [31:0] IX_RINGUP  = 32'd20;
  localparam logic [31:0] IX_SYNC    = 32'd21;
  localparam logic [31:0] IX_BUSY    = 32'd22;
  localparam logic [31:0] IX_GUEST   = 32'd23;
  localparam logic [31:0] IX_CSHAPE  = 32'd24;
  localparam logic [31:0] IX_CX      = 32'd25;
  localparam logic [31:0] IX_CY      = 32'd26;
  localparam logic [31:0] IX_CSHOW   = 32'd27;
  localparam logic [31:0] IX_SCRSIZE = 32'd29;
  localparam logic [31:0] IX_SCRBASE = 32'd1792;

  localparam logic [31:0] ID_BASE  = 32'h9000_0000;
  localparam logic [31:0] CAP_BITS = 32'h0000_0003;

  function automatic logic id_legal(input logic [31:0] v);
    return (v == ID_BASE) || (v == ID_BASE + 32'd1) || (v == ID_BASE + 32'd2);
  endfunction
endpackage

// File: rtl/cfg_ring_check.sv
module cfg_ring_check #(
  parameter logic [31:0] RING_BYTES = 32'h0001_0000,
  parameter logic [31:0] HDR_BYTES  = 32'd16,
  parameter logic [31:0] MIN_SPAN   = 32'd10240
) (
  input  logic [31:0] lo,
  input  logic [31:0] hi,
  input  logic [31:0] wp,
  input  logic [31:0] rp,
  output logic        ok
);
  logic [32:0] need_hi;
  logic        aligned;

  always_comb begin
    need_hi = {1'b0, lo} + {1'b0, MIN_SPAN};
    aligned = ((lo | hi | wp | rp) & 32'd3) == 32'd0;
    ok = aligned && (lo >= HDR_BYTES) && (hi <= RING_BYTES) && ({1'b0, hi} >= need_hi);
  end
endmodule

// File: rtl/cfg_scratch_ram.sv
module cfg_scratch_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfg_regport_pkg::*;
#(
  parameter int DEPTH = 24,
  parameter int MAX_W = 2360,
  parameter int MAX_H = 1770,
  parameter int SCRATCH_WORDS = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] idx,
  input  logic [31:0] wdata,
  input  logic        ring_ok,
  input  logic        mode_apply,
  input  logic        sync_done,
  output logic [31:0] rd_word,
  output logic        disp_enable,
  output logic        ring_ready,
  output logic        cursor_visible,
  output logic        sync_start
);
  localparam logic [31:0] BYTES_PP = 32'((DEPTH + 7) >> 3);
  localparam logic [31:0] BPP      = 32'((DEPTH + 7) / 8 * 8);
  localparam logic [31:0] DEPTH_W  = 32'(DEPTH);

  logic [31:0] id_q, req_w, req_h, act_w, act_h, guest_q, shape_q, cx_q, cy_q;
  logic        en_q, cfg_q, show_q, busy_q, start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q    <= ID_BASE + 32'd2;
      en_q    <= 1'b0;
      cfg_q   <= 1'b0;
      req_w   <= '0;
      req_h   <= '0;
      act_w   <= '1;
      act_h   <= '1;
      guest_q <= '0;
      shape_q <= '0;
      cx_q    <= '0;
      cy_q    <= '0;
      show_q  <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (sync_done) busy_q <= 1'b0;
      if (mode_apply) begin
        act_w <= req_w;
        act_h <= req_h;
      end
      if (wr_en) begin
        case (idx)
          IX_ID:     if (id_legal(wdata)) id_q <= wdata;
          IX_ENABLE: begin
            en_q  <= |wdata;
            if (wdata == '0) cfg_q <= 1'b0;
            act_w <= '1;
            act_h <= '1;
          end
          IX_WIDTH:  req_w <= wdata;
          IX_HEIGHT: req_h <= wdata;
          IX_DEPTH, IX_BPP: if (wdata != DEPTH_W) cfg_q <= 1'b0;
          IX_RINGUP: begin
            if (wdata == '0) cfg_q <= 1'b0;
            else if (ring_ok) cfg_q <= 1'b1;
          end
          IX_SYNC: begin
            busy_q  <= 1'b1;
            start_q <= 1'b1;
          end
          IX_GUEST:  guest_q <= wdata;
          IX_CSHAPE: shape_q <= wdata;
          IX_CX:     cx_q <= wdata;
          IX_CY:     cy_q <= wdata;
          IX_CSHOW: begin
            if (wdata == 32'd1) show_q <= 1'b1;
            else if (wdata == 32'd0) show_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      IX_ID:             rd_word = id_q;
      IX_ENABLE:         rd_word = {31'd0, en_q};
      IX_WIDTH:          rd_word = act_w;
      IX_HEIGHT:         rd_word = act_h;
      IX_MAXW:           rd_word = 32'(MAX_W);
      IX_MAXH:           rd_word = 32'(MAX_H);
      IX_DEPTH:          rd_word = DEPTH_W;
      IX_BPP:            rd_word = BPP;
      IX_PITCH:          rd_word = BYTES_PP * req_w;
      IX_CAPS:           rd_word = CAP_BITS;
      IX_RINGUP:         rd_word = {31'd0, cfg_q};
      IX_SYNC, IX_BUSY:  rd_word = {31'd0, busy_q};
      IX_GUEST:          rd_word = guest_q;
      IX_CSHAPE:         rd_word = shape_q;
      IX_CX:             rd_word = cx_q;
      IX_CY:             rd_word = cy_q;
      IX_CSHOW:          rd_word = {31'd0, show_q};
      IX_SCRSIZE:        rd_word = 32'(SCRATCH_WORDS);
      default:           rd_word = '0;
    endcase
  end

  assign disp_enable    = en_q;
  assign ring_ready     = cfg_q;
  assign cursor_visible = show_q;
  assign sync_start     = start_q;
endmodule

// File: rtl/cfg_regport.sv
module cfg_regport
  import cfg_regport_pkg::*;
#(
  parameter int DEPTH = 24,
  parameter int MAX_W = 2360,
  parameter int MAX_H = 1770,
  parameter int SCRATCH_AW = 10,
  parameter logic [31:0] RING_BYTES = 32'h0001_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [1:0]  io_off,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        io_rvalid,
  input  logic [31:0] ring_lo,
  input  logic [31:0] ring_hi,
  input  logic [31:0] ring_wp,
  input  logic [31:0] ring_rp,
  input  logic        mode_apply,
  input  logic        sync_done,
  output logic        sync_start,
  output logic        disp_enable,
  output logic        ring_ready,
  output logic        cursor_visible
);
  localparam int SCRATCH_WORDS = 1 << SCRATCH_AW;
  localparam logic [31:0] SCR_END = IX_SCRBASE + 32'(SCRATCH_WORDS);

  logic [31:0] index_q, reg_word, ram_q, rd_q;
  logic        ring_ok, val_wr, in_scratch, from_ram_q, rvalid_q;
  logic [SCRATCH_AW-1:0] scr_addr;

  assign val_wr     = io_wr && (io_off == OFF_DATA);
  assign in_scratch = (index_q >= IX_SCRBASE) && (index_q < SCR_END);
  assign scr_addr   = SCRATCH_AW'(index_q - IX_SCRBASE);

  always_ff @(posedge clk) begin
    if (rst) index_q <= '0;
    else if (io_wr && io_off == OFF_SEL) index_q <= io_wdata;
  end

  cfg_ring_check #(.RING_BYTES(RING_BYTES)) u_ring (
    .lo(ring_lo), .hi(ring_hi), .wp(ring_wp), .rp(ring_rp), .ok(ring_ok)
  );

  cfg_scratch_ram #(.AW(SCRATCH_AW), .DW(32)) u_scr (
    .clk(clk), .we(val_wr && in_scratch), .addr(scr_addr),
    .wdata(io_wdata), .q(ram_q)
  );

  cfg_reg_file #(
    .DEPTH(DEPTH), .MAX_W(MAX_W), .MAX_H(MAX_H), .SCRATCH_WORDS(SCRATCH_WORDS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(val_wr), .idx(index_q), .wdata(io_wdata),
    .ring_ok(ring_ok), .mode_apply(mode_apply), .sync_done(sync_done),
    .rd_word(reg_word), .disp_enable(disp_enable), .ring_ready(ring_ready),
    .cursor_visible(cursor_visible), .sync_start(sync_start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q   <= 1'b0;
      rd_q       <= '0;
      from_ram_q <= 1'b0;
    end else begin
      rvalid_q   <= io_rd;
      from_ram_q <= io_rd && (io_off == OFF_DATA) && in_scratch;
      if (io_rd) begin
        case (io_off)
          OFF_SEL:   rd_q <= index_q;
          OFF_DATA:  rd_q <= reg_word;
          OFF_SPARE: rd_q <= '0;
          default:   rd_q <= '1;
        endcase
      end
    end
  end

  assign io_rvalid = rvalid_q;
  assign io_rdata  = from_ram_q ? ram_q : rd_q;
endmodule

// File: rtl/cfg_regport_chk.sv
module cfg_regport_chk (
  input logic        clk,
  input logic        rst,
  input logic        io_wr,
  input logic        io_rd,
  input logic [1:0]  io_off,
  input logic [31:0] io_wdata,
  input logic [31:0] io_rdata,
  input logic        io_rvalid,
  input logic [31:0] index_q,
  input logic        sync_start,
  input logic        ring_ready,
  input logic        cursor_visible
);
  // R1
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    io_rd |=> io_rvalid);
  // R1
  hole_reads_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_off == 2'd3) |=> (io_rdata == 32'hFFFF_FFFF));
  // R8
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    sync_start |-> $past(io_wr && io_off == 2'd1 && index_q == 32'd21));
  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    sync_start |=> !sync_start);
  // R6
  ready_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ring_ready) |-> $past(io_wr && io_off == 2'd1 && index_q == 32'd20 && io_wdata != 32'd0));
  // R3
  disable_drops_ring_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_off == 2'd1 && index_q == 32'd1 && io_wdata == 32'd0) |=> !ring_ready);
  // R9
  cursor_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_off == 2'd1 && index_q == 32'd27 && io_wdata > 32'd1) |=> $stable(cursor_visible));
endmodule

bind cfg_regport cfg_regport_chk u_chk (
  .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_off(io_off),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
  .index_q(index_q), .sync_start(sync_start), .ring_ready(ring_ready),
  .cursor_visible(cursor_visible)
);

// File: tb/test_cfg_regport.sv
`timescale 1ns/1ps
module test_cfg_regport;
  logic clk = 0, rst = 1;
  logic io_wr = 0, io_rd = 0;
  logic [1:0] io_off = 0;
  logic [31:0] io_wdata = 0, io_rdata;
  logic io_rvalid;
  logic [31:0] ring_lo = 0, ring_hi = 0, ring_wp = 0, ring_rp = 0;
  logic mode_apply = 0, sync_done = 0;
  logic sync_start, disp_enable, ring_ready, cursor_visible;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_regport i_cfg_regport (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (!rst && io_rvalid) begin
      if (exp_q.size() == 0) chk("R1 unexpected rvalid", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), io_rdata, exp_q.pop_front());
    end
  end

  task automatic io_write(logic [1:0] off, logic [31:0] d);
    io_wr = 1; io_off = off; io_wdata = d;
    @(posedge clk); #1;
    io_wr = 0;
  endtask

  task automatic io_read(logic [1:0] off, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    io_rd = 1; io_off = off;
    @(posedge clk); #1;
    io_rd = 0;
  endtask

  task automatic setreg(logic [31:0] ix, logic [31:0] v);
    io_write(2'd0, ix); io_write(2'd1, v);
  endtask

  task automatic getreg(logic [31:0] ix, logic [31:0] exp, string tag);
    io_write(2'd0, ix); io_read(2'd1, exp, tag);
  endtask

  task automatic ring(logic [31:0] lo, logic [31:0] hi, logic [31:0] wp, logic [31:0] rp);
    ring_lo = lo; ring_hi = hi; ring_wp = wp; ring_rp = rp;
  endtask

  task automatic pulse_apply();
    mode_apply = 1; @(posedge clk); #1; mode_apply = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // reset state
    chk("R1 reset ring_ready", ring_ready, 0);
    chk("R3 reset enable", disp_enable, 0);
    chk("R9 reset cursor", cursor_visible, 0);
    chk("R8 reset start", sync_start, 0);
    io_read(2'd0, 32'd0, "R1 reset selector");
    // R1 offsets
    io_read(2'd3, 32'hFFFF_FFFF, "R1 offset3 ones");
    io_read(2'd2, 32'd0, "R1 spare reads zero");
    io_write(2'd0, 32'd55);
    io_write(2'd2, 32'd99);
    io_read(2'd0, 32'd55, "R1 spare write ignored");
    // R2 identity
    getreg(0, 32'h9000_0002, "R2 reset id");
    setreg(0, 32'h9000_0001);
    getreg(0, 32'h9000_0001, "R2 legal id");
    setreg(0, 32'h1234_5678);
    getreg(0, 32'h9000_0001, "R2 illegal id");
    setreg(0, 32'h9000_0003);
    getreg(0, 32'h9000_0001, "R2 version 3 rejected");
    // R13 constants
    getreg(17, 32'd3, "R13 caps");
    getreg(4, 32'd2360, "R13 max width");
    getreg(5, 32'd1770, "R13 max height");
    // R5 depth
    getreg(6, 32'd24, "R5 depth");
    getreg(7, 32'd24, "R5 bpp");
    // R4 size
    setreg(2, 32'd640);
    setreg(3, 32'd480);
    getreg(12, 32'd1920, "R4 pitch");
    getreg(2, 32'hFFFF_FFFF, "R4 width before apply");
    pulse_apply();
    getreg(2, 32'd640, "R4 width applied");
    getreg(3, 32'd480, "R4 height applied");
    // R6 ring bring-up
    setreg(1, 32'd1);
    chk("R3 enable set", disp_enable, 1);
    getreg(2, 32'hFFFF_FFFF, "R3 width invalid after enable");
    ring(16, 16 + 10240, 16, 16);
    setreg(20, 32'd1);
    chk("R6 minimal span accepted", ring_ready, 1);
    getreg(20, 32'd1, "R6 readback");
    setreg(20, 32'd0);
    chk("R7 zero write drops", ring_ready, 0);
    ring(16, 16 + 10240, 16, 18);
    setreg(20, 32'd1);
    chk("R6 misaligned rejected", ring_ready, 0);
    ring(12, 32'h1_0000, 12, 12);
    setreg(20, 32'd1);
    chk("R6 low start rejected", ring_ready, 0);
    ring(16, 32'h1_0004, 16, 16);
    setreg(20, 32'd1);
    chk("R6 high end rejected", ring_ready, 0);
    ring(16, 16 + 10236, 16, 16);
    setreg(20, 32'd1);
    chk("R6 short span rejected", ring_ready, 0);
    ring(16, 32'h1_0000, 32, 64);
    setreg(20, 32'd1);
    chk("R6 full range accepted", ring_ready, 1);
    ring(16, 16 + 10236, 16, 16);
    setreg(20, 32'd1);
    chk("R6 failed check keeps state", ring_ready, 1);
    // R5 depth writes
    setreg(6, 32'd24);
    chk("R5 equal depth keeps ring", ring_ready, 1);
    setreg(7, 32'd16);
    chk("R5 depth mismatch drops ring", ring_ready, 0);
    // R3 disable
    ring(16, 32'h1_0000, 16, 16);
    setreg(20, 32'd1);
    chk("R6 re-up", ring_ready, 1);
    setreg(1, 32'd0);
    chk("R3 disable drops ring", ring_ready, 0);
    chk("R3 disable output", disp_enable, 0);
    getreg(1, 32'd0, "R3 enable reads 0");
    setreg(1, 32'd5);
    getreg(1, 32'd1, "R3 nonzero reads 1");
    // R8 sync
    setreg(21, 32'd0);
    chk("R8 start pulse", sync_start, 1);
    @(posedge clk); #1;
    chk("R8 start one cycle", sync_start, 0);
    getreg(22, 32'd1, "R8 busy set");
    getreg(21, 32'd1, "R8 sync reads busy");
    sync_done = 1; @(posedge clk); #1; sync_done = 0;
    getreg(22, 32'd0, "R8 busy cleared");
    // R9 cursor
    setreg(27, 32'd1);
    chk("R9 show", cursor_visible, 1);
    setreg(27, 32'd2);
    chk("R9 value 2 holds", cursor_visible, 1);
    setreg(27, 32'd0);
    chk("R9 hide", cursor_visible, 0);
    setreg(27, 32'd3);
    chk("R9 value 3 holds", cursor_visible, 0);
    getreg(27, 32'd0, "R9 readback");
    // R10 plain words
    setreg(23, 32'h5007);
    setreg(24, 32'h77);
    setreg(25, 32'd100);
    setreg(26, 32'd200);
    getreg(23, 32'h5007, "R10 guest");
    getreg(24, 32'h77, "R10 shape");
    getreg(25, 32'd100, "R10 cursor x");
    getreg(26, 32'd200, "R10 cursor y");
    // R11 palette and unknown
    setreg(1024, 32'hAB);
    getreg(1024, 32'd0, "R11 palette low");
    setreg(1791, 32'hCD);
    getreg(1791, 32'd0, "R11 palette high");
    setreg(40, 32'hEF);
    getreg(40, 32'd0, "R11 unknown");
    // R12 scratch
    setreg(1792, 32'hA5A5_0001);
    setreg(1792 + 1023, 32'h5A5A_0002);
    getreg(1792, 32'hA5A5_0001, "R12 scratch first");
    getreg(1792 + 1023, 32'h5A5A_0002, "R12 scratch last");
    getreg(29, 32'd1024, "R12 size");
    setreg(1792 + 1024, 32'h1111);
    getreg(1792 + 1024, 32'd0, "R12 past bank");
    getreg(1792, 32'hA5A5_0001, "R12 bank untouched");
    repeat (3) @(posedge clk);
    #1;
    chk("R1 all reads returned", exp_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule